// File: doc/BRIEF.md
# Lockable Identifier Register Bank

This block holds a 64-bit identifier as eight byte-wide registers behind a plain register bus made of an address, write data, a single-cycle write strobe and a combinational read-data output. Until the part is sealed, the identifier bytes behave as ordinary scratch storage. Software may rewrite them as often as it likes, and each write lands on the clock edge where the strobe is high.

A control register at a separate address carries a sticky seal bit next to seven ordinary read/write bits. When a 1 is written into the seal bit, the identifier bytes become read-only for good, and no later write can clear the seal. Only a synchronous reset returns the bank to its blank state, with all bytes and all control bits at zero. The bus has no back-pressure. Every write is taken in the cycle it is presented, and read data follows the address in the same cycle, so no valid/ready handshake is needed at this edge.

Top module: `id_lock_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, all eight identifier bytes and all eight control bits are cleared to 00h, and this also clears a seal that was set before.
- R2: While unsealed, a write to address 10h+i (i = 0..7) stores `wdata` in byte i at that clock edge, and reading 10h+i then returns the stored value. Bytes may be rewritten without limit, and a byte that was never written reads 00h.
- R3: A write to address 18h with `wdata` bit 7 = 1 sets the seal, and control bit 7 then reads back as 1.
- R4: While sealed, writes to addresses 10h through 17h are ignored and leave every identifier byte unchanged.
- R5: Once set, the seal (bit 7 of address 18h) stays 1 after any write to 18h, including a write of 00h.
- R6: While sealed, the identifier bytes still read back their stored values.
- R7: Bits 6:0 of address 18h are plain read/write bits, both before and after the seal is set.
- R8: A read of any address outside 10h through 18h returns 00h, and a write to such an address changes no register.
- R9: A write to an identifier byte in the cycle right after the sealing write is already blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe; one write per high cycle |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The bound checker watches on every cycle that the seal never falls outside reset, that identifier bytes never move while sealed, that each unsealed byte write and each control write lands next cycle, and that unmapped reads return zero. Some behaviours show up only in the bench scenarios: the full write-then-read story across all byte positions, the fact that writes to unmapped addresses disturb nothing, that a reset really brings back a blank and unsealed bank, and that a byte write issued back-to-back with the sealing write is refused.

// File: rtl/id_lock_pkg.sv
package id_lock_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/id_addr_decode.sv
module id_addr_decode
  import id_lock_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              ID_BYTES  = 8,
  parameter logic [ADDR_W-1:0] ID_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_AD = 8'h18,
  localparam int             IDX_W     = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] ID_END = ID_BASE + ADDR_W'(ID_BYTES);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - ID_BASE;
    idx    = offset[IDX_W-1:0];
    if (addr == CTRL_AD)
      sel = SEL_CTRL;
    else if (addr >= ID_BASE && addr < ID_END)
      sel = SEL_ID;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/id_byte_bank.sv
module id_byte_bank #(
  parameter int  DATA_W   = 8,
  parameter int  ID_BYTES = 8,
  localparam int IDX_W    = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic                         sealed,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [ID_BYTES*DATA_W-1:0]   id_flat
);
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= '0;
      else if (we && !sealed && idx == IDX_W'(g))
        byte_q <= wdata;
    end
    assign id_flat[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/id_seal_ctrl.sv
module id_seal_ctrl #(
  parameter int  DATA_W   = 8,
  parameter int  SEAL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              sealed
);
  localparam logic [DATA_W-1:0] SEAL_MASK = DATA_W'(1) << SEAL_BIT;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (we)
      ctrl_q <= wdata | (ctrl_q & SEAL_MASK);
  end

  assign sealed = ctrl_q[SEAL_BIT];
endmodule

// File: rtl/id_lock_regfile.sv
module id_lock_regfile
  import id_lock_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter int                ID_BYTES = 8,
  parameter logic [ADDR_W-1:0] ID_BASE  = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_AD  = 8'h18,
  parameter int                SEAL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  reg_sel_e                   sel;
  logic [IDX_W-1:0]           idx;
  logic [ID_BYTES*DATA_W-1:0] id_flat;
  logic [DATA_W-1:0]          ctrl_q;
  logic                       sealed;

  id_addr_decode #(
    .ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES), .ID_BASE(ID_BASE), .CTRL_AD(CTRL_AD)
  ) u_dec (
    .addr(addr), .sel(sel), .idx(idx)
  );

  id_byte_bank #(
    .DATA_W(DATA_W), .ID_BYTES(ID_BYTES)
  ) u_bank (
    .clk(clk), .rst(rst), .we(wr_en && sel == SEL_ID), .sealed(sealed),
    .idx(idx), .wdata(wdata), .id_flat(id_flat)
  );

  id_seal_ctrl #(
    .DATA_W(DATA_W), .SEAL_BIT(SEAL_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .we(wr_en && sel == SEL_CTRL), .wdata(wdata),
    .ctrl_q(ctrl_q), .sealed(sealed)
  );

  always_comb begin
    unique case (sel)
      SEL_ID:   rdata = id_flat[idx*DATA_W +: DATA_W];
      SEL_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/id_lock_chk.sv
module id_lock_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter int                ID_BYTES = 8,
  parameter logic [ADDR_W-1:0] ID_BASE  = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_AD  = 8'h18,
  parameter int                SEAL_BIT = 7
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            wdata,
  input logic [DATA_W-1:0]            rdata,
  input logic [ID_BYTES*DATA_W-1:0]   id_flat,
  input logic [DATA_W-1:0]            ctrl_q
);
  localparam int                IDX_W  = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam logic [ADDR_W-1:0] ID_END = ID_BASE + ADDR_W'(ID_BYTES);

  logic              in_id, in_ctrl, unmapped;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] wr_byte;

  assign in_id    = (addr >= ID_BASE) && (addr < ID_END);
  assign in_ctrl  = (addr == CTRL_AD);
  assign unmapped = !in_id && !in_ctrl;
  assign off      = addr - ID_BASE;

  always_ff @(posedge clk) widx <= off[IDX_W-1:0];
  assign wr_byte = id_flat[widx*DATA_W +: DATA_W];

  // R5: the seal never drops outside reset
  assert_seal_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[SEAL_BIT] |=> ctrl_q[SEAL_BIT]);

  // R4: sealed bytes never change
  assert_bytes_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[SEAL_BIT] |=> $stable(id_flat));

  // R2: unsealed byte write lands on the next cycle
  assert_byte_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_id && !ctrl_q[SEAL_BIT]) |=> (wr_byte == $past(wdata)));

  // R3: writing a 1 to the seal bit sets it
  assert_seal_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_ctrl && wdata[SEAL_BIT]) |=> ctrl_q[SEAL_BIT]);

  // R7: low control bits follow the written value
  assert_ctrl_low_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_ctrl) |=> (ctrl_q[SEAL_BIT-1:0] == $past(wdata[SEAL_BIT-1:0])));

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (rdata == '0));
endmodule

bind id_lock_regfile id_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES),
  .ID_BASE(ID_BASE), .CTRL_AD(CTRL_AD), .SEAL_BIT(SEAL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .id_flat(id_flat), .ctrl_q(ctrl_q)
);

// File: tb/tb_id_lock_regfile.sv
`timescale 1ns/1ps
module tb_id_lock_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  id_lock_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  typedef struct packed {
    logic       is_wr;
    logic [7:0] a;
    logic [7:0] d;   // write data, or expected read data
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 8'h11, 4'd2},  // R2
    '{1'b1, 8'h17, 8'h77, 4'd2},  // R2
    '{1'b0, 8'h10, 8'h11, 4'd2},  // R2
    '{1'b0, 8'h17, 8'h77, 4'd2},  // R2
    '{1'b1, 8'h10, 8'h5A, 4'd2},  // R2 rewrite
    '{1'b0, 8'h10, 8'h5A, 4'd2},  // R2
    '{1'b1, 8'h13, 8'hC3, 4'd2},  // R2
    '{1'b0, 8'h13, 8'hC3, 4'd2},  // R2
    '{1'b0, 8'h11, 8'h00, 4'd2},  // R2 untouched byte
    '{1'b0, 8'h0F, 8'h00, 4'd8},  // R8
    '{1'b0, 8'h19, 8'h00, 4'd8},  // R8
    '{1'b1, 8'h19, 8'hEE, 4'd8},  // R8 unmapped write
    '{1'b0, 8'h19, 8'h00, 4'd8},  // R8
    '{1'b1, 8'h18, 8'h25, 4'd7},  // R7
    '{1'b0, 8'h18, 8'h25, 4'd7},  // R7
    '{1'b1, 8'h18, 8'h81, 4'd3},  // R3 seal
    '{1'b0, 8'h18, 8'h81, 4'd3},  // R3
    '{1'b1, 8'h10, 8'hFF, 4'd4},  // R4
    '{1'b0, 8'h10, 8'h5A, 4'd6},  // R6 / R4
    '{1'b1, 8'h17, 8'h00, 4'd4},  // R4
    '{1'b0, 8'h17, 8'h77, 4'd6},  // R6 / R4
    '{1'b1, 8'h18, 8'h00, 4'd5},  // R5
    '{1'b0, 8'h18, 8'h80, 4'd5},  // R5
    '{1'b1, 8'h18, 8'h3C, 4'd7},  // R7 after seal
    '{1'b0, 8'h18, 8'hBC, 4'd7}   // R7
  };

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    addr = a;
    #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: blank state after reset
    for (int i = 0; i < 9; i++) chk_rd(8'h10 + 8'(i), 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) do_wr(VEC[i].a, VEC[i].d);
      else chk_rd(VEC[i].a, VEC[i].d, int'(VEC[i].req));
    end

    // R1: reset clears a seal; bytes writable again
    do_reset();
    chk_rd(8'h18, 8'h00, 1);
    chk_rd(8'h10, 8'h00, 1);

    // R9: byte write right behind the sealing write is blocked
    do_wr(8'h12, 8'h44);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h18; wdata = 8'h80;
    @(negedge clk);
    addr = 8'h12; wdata = 8'h99;
    @(negedge clk);
    wr_en = 1'b0;
    chk_rd(8'h12, 8'h44, 9);
    chk_rd(8'h18, 8'h80, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule